// File: doc/BRIEF.md
# Half-Bridge Short-Circuit Fault Detector

This block watches the output nodes of a set of half-bridge phases (two by default) and raises one shared fault flag when a phase output sits at a level the gate drive cannot explain. Each phase supplies the effective top and bottom gate enables and a digitized level sense of its output node. A top switch that is on with the node sensed low points to a short to ground or to another phase. A bottom switch that is on with the node sensed high points to a short to the supply or to another phase.

Switching edges leave the output node in transit, so the comparison is masked for a fixed number of clock cycles. That window starts again on any change of any gate enable, on a pulse of the switching-event input from the gate controller, and on reset. The flag only reports the fault. The block drives no gates, and acting on the flag is the job of an external controller. The flag is not latched: it tracks the live, unmasked mismatch one clock later.

Top module: `sc_short_detect`

## Requirements
- R1: Synchronous active-high `rst` forces `short_flag` low and starts a blanking window. With gates held stable and a mismatch present, the flag rises on exactly the `BLANK_CYC`-th rising edge after the first edge that samples `rst` low.
- R2: A phase whose top enable is 1 and bottom enable is 0 expects a sensed level of 1. A sensed 0 there, outside blanking, sets `short_flag` on the next edge.
- R3: A phase whose bottom enable is 1 and top enable is 0 expects a sensed level of 0. A sensed 1 there, outside blanking, sets `short_flag` on the next edge.
- R4: While every checked phase senses its expected level, `short_flag` is 0 on the following edge.
- R5: A phase with both enables 0, or with both enables 1, is left out of the check, and its sensed level has no effect on `short_flag`.
- R6: Any change of any bit of `top_en` or `bot_en` restarts the window. `short_flag` is 0 for the next `BLANK_CYC` edges, and a mismatch that persists is flagged on edge `BLANK_CYC`+1.
- R7: A one-cycle pulse on `sw_evt` restarts the window in the same way as a gate change. A flag that is already set drops on the next edge.
- R8: `short_flag` is not latched. It returns to 0 one edge after the mismatch clears.
- R9: A single flag covers all phases. Bit i of `top_en`, `bot_en` and `lvl_hi` belongs to phase i, and a mismatch on any phase raises the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| top_en | input | NUM_PH | Effective top-switch enable per phase (bit i = phase i) |
| bot_en | input | NUM_PH | Effective bottom-switch enable per phase |
| lvl_hi | input | NUM_PH | Digitized output level per phase, 1 = near supply |
| sw_evt | input | 1 | Switching-event pulse from the gate controller |
| short_flag | output | 1 | Active-high short-circuit indication for all phases |

## Verification
The bench builds the block with `NUM_PH` = 2 and `BLANK_CYC` = 4. This short window lets every masked edge and the exact release edge be checked one by one after a reset, a gate change and a switching-event pulse. Two phases are enough to show that each phase raises the shared flag alone, and that idle or doubly enabled phases are left out while the other phase stays checked.

// File: rtl/sc_pkg.sv
package sc_pkg;
    // Level a phase output is expected to show for its gate state
    typedef enum logic [1:0] {
        EXP_NONE = 2'd0,
        EXP_HIGH = 2'd1,
        EXP_LOW  = 2'd2
    } sc_expect_e;
endpackage

// File: rtl/sc_phase_cmp.sv
module sc_phase_cmp
    import sc_pkg::*;
(
    input  logic top,
    input  logic bot,
    input  logic lvl,
    output logic mismatch
);
    sc_expect_e expect_lvl;

    always_comb begin
        if (top && !bot)      expect_lvl = EXP_HIGH;
        else if (bot && !top) expect_lvl = EXP_LOW;
        else                  expect_lvl = EXP_NONE;
        mismatch = ((expect_lvl == EXP_HIGH) && !lvl) ||
                   ((expect_lvl == EXP_LOW)  &&  lvl);
    end
endmodule

// File: rtl/sc_blank_timer.sv
module sc_blank_timer #(
    parameter int BLANK_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic blank
);
    localparam int CW = (BLANK_CYC > 1) ? $clog2(BLANK_CYC) : 1;
    localparam logic [CW-1:0] LOAD = CW'(BLANK_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (rst || restart)
            tmr_d.cnt = LOAD;
        else if (tmr_q.cnt != '0)
            tmr_d.cnt = tmr_q.cnt - CW'(1);
        blank = restart || (tmr_q.cnt != '0);
    end

    always_ff @(posedge clk) begin
        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/sc_short_detect.sv
module sc_short_detect #(
    parameter int NUM_PH    = 2,
    parameter int BLANK_CYC = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_PH-1:0] top_en,
    input  logic [NUM_PH-1:0] bot_en,
    input  logic [NUM_PH-1:0] lvl_hi,
    input  logic              sw_evt,
    output logic              short_flag
);
    typedef struct packed {
        logic [NUM_PH-1:0] top;
        logic [NUM_PH-1:0] bot;
        logic              fault;
    } det_t;

    det_t              det_d, det_q;
    logic [NUM_PH-1:0] ph_mis;
    logic              gate_chg;
    logic              restart;
    logic              blank;

    for (genvar i = 0; i < NUM_PH; i++) begin : g_ph
        sc_phase_cmp u_cmp (
            .top      (top_en[i]),
            .bot      (bot_en[i]),
            .lvl      (lvl_hi[i]),
            .mismatch (ph_mis[i])
        );
    end

    sc_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .blank   (blank)
    );

    always_comb begin
        gate_chg = (top_en != det_q.top) || (bot_en != det_q.bot);
        restart  = gate_chg || sw_evt;
        det_d.top   = top_en;
        det_d.bot   = bot_en;
        det_d.fault = !rst && !blank && (|ph_mis);
    end

    always_ff @(posedge clk) begin
        det_q <= det_d;
    end

    assign short_flag = det_q.fault;
endmodule

// File: rtl/sc_flag_chk.sv
module sc_flag_chk #(
    parameter int NUM_PH = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_PH-1:0] top_en,
    input logic [NUM_PH-1:0] bot_en,
    input logic [NUM_PH-1:0] lvl_hi,
    input logic              sw_evt,
    input logic              short_flag
);
    logic [NUM_PH-1:0] port_mis;
    assign port_mis = (top_en & ~bot_en & ~lvl_hi) | (bot_en & ~top_en & lvl_hi);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> !short_flag); // R1

    AST_MATCH_QUIET: assert property (@(posedge clk) disable iff (rst)
        (port_mis == '0) |=> !short_flag); // R4

    AST_UNCHECKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        ((top_en ^ bot_en) == '0) |=> !short_flag); // R5

    AST_GATE_CHANGE_MASKS: assert property (@(posedge clk) disable iff (rst)
        ({top_en, bot_en} != $past({top_en, bot_en})) |=> !short_flag); // R6

    AST_EVENT_MASKS: assert property (@(posedge clk) disable iff (rst)
        sw_evt |=> !short_flag); // R7
endmodule

bind sc_short_detect sc_flag_chk #(.NUM_PH(NUM_PH)) u_flag_chk (
    .clk        (clk),
    .rst        (rst),
    .top_en     (top_en),
    .bot_en     (bot_en),
    .lvl_hi     (lvl_hi),
    .sw_evt     (sw_evt),
    .short_flag (short_flag)
);

// File: tb/sim_sc_short_detect.sv
`timescale 1ns/1ps
module sim_sc_short_detect;
    localparam int NP = 2;
    localparam int B  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] top_en = '0;
    logic [NP-1:0] bot_en = '0;
    logic [NP-1:0] lvl_hi = '0;
    logic          sw_evt = 1'b0;
    logic          short_flag;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sc_short_detect #(.NUM_PH(NP), .BLANK_CYC(B)) u0 (
        .clk(clk), .rst(rst), .top_en(top_en), .bot_en(bot_en),
        .lvl_hi(lvl_hi), .sw_evt(sw_evt), .short_flag(short_flag)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic exp);
        n_chk++;
        if (short_flag !== exp) begin
            n_fail++;
            $display("FAIL %s: short_flag=%b expected=%b at %0t", req, short_flag, exp, $time);
        end
    endtask

    // R1 and R2: reset clears, then window of B edges before the flag
    task automatic t_reset();
        rst = 1'b1; top_en = 2'b01; bot_en = 2'b00; lvl_hi = 2'b00;
        tick(3);
        chk("R1", 1'b0);
        rst = 1'b0;
        for (int i = 1; i < B; i++) begin
            tick(1);
            chk("R1", 1'b0);
        end
        tick(1);
        chk("R2", 1'b1);
    endtask

    // R4 and R8: matching level clears the flag one edge later
    task automatic t_match();
        lvl_hi = 2'b01;
        tick(1);
        chk("R8", 1'b0);
        tick(3);
        chk("R4", 1'b0);
        lvl_hi = 2'b00;
        tick(1);
        chk("R2", 1'b1);
    endtask

    // R6 and R3: gate change masks B edges, then bottom-on/high is flagged
    task automatic t_gate_change();
        top_en = 2'b00; bot_en = 2'b01; lvl_hi = 2'b01;
        for (int i = 1; i <= B; i++) begin
            tick(1);
            chk("R6", 1'b0);
        end
        tick(1);
        chk("R3", 1'b1);
    endtask

    // R7: switching event drops the flag and masks B edges
    task automatic t_event();
        sw_evt = 1'b1;
        tick(1);
        chk("R7", 1'b0);
        sw_evt = 1'b0;
        for (int i = 2; i <= B; i++) begin
            tick(1);
            chk("R7", 1'b0);
        end
        tick(1);
        chk("R7", 1'b1);
    endtask

    // R5: idle and doubly enabled phases are ignored
    task automatic t_unchecked();
        top_en = 2'b00; bot_en = 2'b00; lvl_hi = 2'b11;
        tick(B + 2);
        chk("R5", 1'b0);
        lvl_hi = 2'b00;
        tick(2);
        chk("R5", 1'b0);
        top_en = 2'b11; bot_en = 2'b11; lvl_hi = 2'b10;
        tick(B + 2);
        chk("R5", 1'b0);
    endtask

    // R9: phase 1 alone raises the shared flag; phase 0 idle
    task automatic t_phase1();
        top_en = 2'b10; bot_en = 2'b00; lvl_hi = 2'b01;
        tick(B + 1);
        chk("R9", 1'b1);
        lvl_hi = 2'b10;
        tick(1);
        chk("R8", 1'b0);
        lvl_hi = 2'b00;
        tick(1);
        chk("R9", 1'b1);
        lvl_hi = 2'b10;
        tick(1);
        chk("R8", 1'b0);
    endtask

    initial begin
        tick(1);
        t_reset();
        t_match();
        t_gate_change();
        t_event();
        t_unchecked();
        t_phase1();
        tick(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule